// File: doc/BRIEF.md
# Exception Frame Sequencer

This block runs the memory side of a processor's exception entry and exception return. On entry it takes a vector number, the status word in force before the exception, the return PC, the current PC and a fault address. It moves into supervisor state, builds a typed frame on the active supervisor stack with a chain of word and longword writes, then reads the handler address from the vector table. On return it unwinds a frame from the active stack, restores the status word and the PC, and discards any extra words that the frame's format code says are present.

The three stack pointers (user, interrupt, master) are held inside the block. The status word picks which one is active: the supervisor bit is bit 13 and the master bit is bit 12. A hardware interrupt taken while the master bit is set builds one frame on the master stack and a second frame on the interrupt stack. On return, a frame whose format code is 1 only reloads the status word, which can change the active stack, and the unwind then continues from the next frame.

Top module: `exc_frame_seq`

## Requirements
- R1: After reset `busy` and `done` are low, `srOut` is 0x2700, `pcOut` is 0 and every stack pointer is 0.
- R2: On entry the new status word is the old one with bit 13 (supervisor) set and bit 15 (trace) cleared. For a hardware entry, bits 10:8 (interrupt mask) are also replaced by `pendLevel`.
- R3: An entry frame is written downward. The stack pointer drops by 2 or 4 before each write. The word at the final SP holds the old status word, the longword at SP+2 the return PC, and the word at SP+6 the format/vector word. All data is big-endian.
- R4: Format 2 and 3 frames hold `faultAddr` as one extra longword at SP+8. A format 4 frame holds `faultAddr` at SP+8 and `curPc` at SP+12. Every other format has no extra data. A hardware entry always uses format 0 and ignores `entryFmt`.
- R5: The format/vector word is the format code in bits 15:12 plus four times the vector number.
- R6: After the frame is written, `pcOut` becomes the longword read at `vbr` plus four times the vector number. `done` is high for exactly one cycle after that load, and `busy` is high from the cycle after a start until then.
- R7: With `SP_ALIGN` set, bit 0 of the active stack pointer is cleared before the first push of each frame.
- R8: A hardware entry with the old master bit set writes a format 0 frame carrying the old status word on the master stack. It then clears the master bit and writes a format 1 frame carrying the updated status word on the interrupt stack.
- R9: A return reads the status word at SP, the PC at SP+2 and the format word at SP+6. It then adds 8 plus 0, 4, 4, 8 or 52 bytes to SP for format 0, 2, 3, 4 or 7, and loads the status word and the PC.
- R10: A return that finds format 1 pops the 8-byte frame, loads its status word, and then unwinds the next frame on the stack that the new status word selects.
- R11: `spOut` shows the user stack when bit 13 is clear, the master stack when bits 13 and 12 are set, and otherwise the interrupt stack.
- R12: `memReq` stays high, with a stable address, until `memAck` is seen. `memLong` is high for 32-bit accesses and low for 16-bit accesses, which use `memWData[15:0]` or `memRData[15:0]`.
- R13: `spWrEn` loads `spWrData` into the stack pointer picked by `spWrSel`: 0 is user, 1 is interrupt, 2 is master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startEntry | input | 1 | Start exception entry (taken when idle) |
| startReturn | input | 1 | Start exception return (taken when idle) |
| isHw | input | 1 | Entry is a hardware interrupt |
| entryFmt | input | 4 | Frame format code for a software entry |
| vecNum | input | VEC_W | Vector number |
| oldSr | input | 16 | Status word before the exception |
| pendLevel | input | 3 | Pending interrupt level for a hardware entry |
| retPc | input | 32 | Return PC stored in the frame |
| curPc | input | 32 | Current PC stored by format 4 |
| faultAddr | input | 32 | Fault or instruction address for formats 2, 3, 4 |
| vbr | input | 32 | Vector table base |
| spWrEn | input | 1 | Load a stack pointer |
| spWrSel | input | 2 | Stack pointer to load |
| spWrData | input | 32 | Stack pointer load value |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Access is a write |
| memLong | output | 1 | Access is 32-bit (else 16-bit) |
| memAddr | output | 32 | Byte address |
| memWData | output | 32 | Write data |
| memRData | input | 32 | Read data |
| memAck | input | 1 | Access complete |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when the new PC is loaded |
| srOut | output | 16 | Current status word |
| pcOut | output | 32 | Current PC |
| spOut | output | 32 | Active stack pointer |

## Verification
A wrong stack index or a missed decrement shows up in the frame words and in `spOut` as soon as the sequence finishes. The return that follows then gives back the wrong PC or status word. A wrong format decode leaves SP off by the skipped byte count once the return completes. For a throwaway frame, the error also surfaces in the next frame read on the other stack. A status word that is updated wrongly on entry appears on `srOut` one cycle after the start, and in the copy pushed into the second frame of a master-mode interrupt.

// File: rtl/exfs_pkg.sv
package exfs_pkg;
  localparam int LW = 32;
  localparam int WW = 16;
  localparam int SR_T = 15;
  localparam int SR_S = 13;
  localparam int SR_M = 12;
  localparam int SR_IHI = 10;
  localparam int SR_ILO = 8;

  typedef enum logic [2:0] {PS_NONE, PS_CURPC, PS_FAULT, PS_FMTVEC, PS_RETPC, PS_SR} pushSel_e;
  typedef enum logic [2:0] {RS_NONE, RS_SR, RS_PC, RS_FMT, RS_VEC} readSel_e;

  typedef struct packed {
    logic       capture;
    pushSel_e   pushSel;
    readSel_e   readSel;
    logic       clrMaster;
    logic       commitRet;
    logic       commitThrow;
    logic [3:0] fmtCode;
  } strobe_t;
endpackage

// File: rtl/exfs_datapath.sv
module exfs_datapath
  import exfs_pkg::*;
#(
  parameter int VEC_W = 8,
  parameter logic [WW-1:0] SR_RST = 16'h2700,
  parameter bit SP_ALIGN = 1'b1
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       stb,
  input  logic          memAck,
  input  logic          isHw,
  input  logic [WW-1:0] oldSr,
  input  logic [2:0]    pendLevel,
  input  logic [VEC_W-1:0] vecNum,
  input  logic [LW-1:0] retPc,
  input  logic [LW-1:0] curPc,
  input  logic [LW-1:0] faultAddr,
  input  logic [LW-1:0] vbr,
  input  logic          spWrEn,
  input  logic [1:0]    spWrSel,
  input  logic [LW-1:0] spWrData,
  input  logic [LW-1:0] memRData,
  output logic [LW-1:0] memAddr,
  output logic [LW-1:0] memWData,
  output logic          memWe,
  output logic          memLong,
  output logic [3:0]    fmtRd,
  output logic [WW-1:0] srOut,
  output logic [LW-1:0] pcOut,
  output logic [LW-1:0] spOut
);
  localparam logic [LW-1:0] ALIGN_MASK = {{(LW-1){1'b1}}, ~SP_ALIGN};

  logic [WW-1:0] srQ, frameSrQ, tmpSrQ, newSr;
  logic [LW-1:0] pcQ, tmpPcQ, retPcQ, curPcQ, faultQ;
  logic [VEC_W-1:0] vecQ;
  logic [3:0] fmtQ;
  logic [LW-1:0] spBank [3];
  logic [1:0] curIdx, newIdx;
  logic [LW-1:0] spAct, skipBytes, stepBytes;
  logic pushing, reading;

  function automatic logic [1:0] actIdx(input logic [WW-1:0] s);
    return s[SR_S] ? (s[SR_M] ? 2'd2 : 2'd1) : 2'd0;
  endfunction

  always_comb begin
    newSr = oldSr;
    newSr[SR_S] = 1'b1;
    newSr[SR_T] = 1'b0;
    if (isHw) newSr[SR_IHI:SR_ILO] = pendLevel;
  end

  assign curIdx  = actIdx(srQ);
  assign newIdx  = actIdx(newSr);
  assign spAct   = spBank[curIdx];
  assign pushing = (stb.pushSel != PS_NONE);
  assign reading = (stb.readSel != RS_NONE);

  always_comb begin
    memLong  = 1'b1;
    memWData = '0;
    unique case (stb.pushSel)
      PS_CURPC:  memWData = curPcQ;
      PS_FAULT:  memWData = faultQ;
      PS_RETPC:  memWData = retPcQ;
      PS_FMTVEC: begin memLong = 1'b0; memWData = {16'h0, stb.fmtCode, 12'({vecQ, 2'b00})}; end
      PS_SR:     begin memLong = 1'b0; memWData = {16'h0, frameSrQ}; end
      default:   memLong = !(stb.readSel == RS_SR || stb.readSel == RS_FMT);
    endcase
    stepBytes = memLong ? LW'(4) : LW'(2);
    if (pushing) memAddr = spAct - stepBytes;
    else if (stb.readSel == RS_VEC) memAddr = vbr + LW'({vecQ, 2'b00});
    else memAddr = spAct;
  end
  assign memWe = pushing;

  always_comb begin
    unique case (fmtQ)
      4'd2, 4'd3: skipBytes = LW'(4);
      4'd4:       skipBytes = LW'(8);
      4'd7:       skipBytes = LW'(52);
      default:    skipBytes = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srQ <= SR_RST; pcQ <= '0; frameSrQ <= '0; tmpSrQ <= '0; tmpPcQ <= '0;
      retPcQ <= '0; curPcQ <= '0; faultQ <= '0; vecQ <= '0; fmtQ <= '0;
      for (int i = 0; i < 3; i++) spBank[i] <= '0;
    end else begin
      if (spWrEn && spWrSel != 2'd3) spBank[spWrSel] <= spWrData;
      if (stb.capture) begin
        srQ <= newSr; frameSrQ <= oldSr; retPcQ <= retPc; curPcQ <= curPc;
        faultQ <= faultAddr; vecQ <= vecNum;
        spBank[newIdx] <= spBank[newIdx] & ALIGN_MASK;
      end
      if (stb.clrMaster) begin
        frameSrQ <= srQ;
        srQ[SR_M] <= 1'b0;
        spBank[1] <= spBank[1] & ALIGN_MASK;
      end
      if (memAck && pushing) spBank[curIdx] <= memAddr;
      if (memAck && reading) begin
        unique case (stb.readSel)
          RS_SR:  begin tmpSrQ <= memRData[WW-1:0]; spBank[curIdx] <= spAct + LW'(2); end
          RS_PC:  begin tmpPcQ <= memRData; spBank[curIdx] <= spAct + LW'(4); end
          RS_FMT: begin fmtQ <= memRData[15:12]; spBank[curIdx] <= spAct + LW'(2); end
          default: pcQ <= memRData;
        endcase
      end
      if (stb.commitRet) begin
        spBank[curIdx] <= spAct + skipBytes;
        srQ <= tmpSrQ;
        pcQ <= tmpPcQ;
      end
      if (stb.commitThrow) srQ <= tmpSrQ;
    end
  end

  assign fmtRd = fmtQ;
  assign srOut = srQ;
  assign pcOut = pcQ;
  assign spOut = spAct;

  AST_ENTRY_SUPER: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |=> (srOut[SR_S] && !srOut[SR_T])); // R2
  AST_PUSH_DECR: assert property (@(posedge clk) disable iff (!rstN)
    (pushing && memAck && !spWrEn) |=> (spOut == $past(memAddr))); // R3
  AST_PUSH_EVEN: assert property (@(posedge clk) disable iff (!rstN)
    (SP_ALIGN && pushing) |-> !memAddr[0]); // R7
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ((pushing || reading) && !memAck && !spWrEn) |=> $stable(memAddr)); // R12
endmodule

// File: rtl/exfs_ctrl.sv
module exfs_ctrl
  import exfs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startEntry,
  input  logic       startReturn,
  input  logic       isHw,
  input  logic       oldSrM,
  input  logic [3:0] entryFmt,
  input  logic       memAck,
  input  logic [3:0] fmtRd,
  output strobe_t    stb,
  output logic       memReq,
  output logic       busy,
  output logic       done
);
  typedef enum logic [3:0] {
    ST_IDLE, ST_P_CURPC, ST_P_FAULT, ST_P_FMTVEC, ST_P_RETPC, ST_P_SR,
    ST_SWITCH, ST_VEC, ST_R_SR, ST_R_PC, ST_R_FMT, ST_R_DEC
  } state_e;

  state_e state;
  logic [3:0] fmtQ;
  logic twoQ, doneQ;
  logic [3:0] firstFmt;

  assign firstFmt = isHw ? 4'd0 : entryFmt;

  always_comb begin
    stb = '0;
    stb.fmtCode = fmtQ;
    unique case (state)
      ST_IDLE:     stb.capture = startEntry;
      ST_P_CURPC:  stb.pushSel = PS_CURPC;
      ST_P_FAULT:  stb.pushSel = PS_FAULT;
      ST_P_FMTVEC: stb.pushSel = PS_FMTVEC;
      ST_P_RETPC:  stb.pushSel = PS_RETPC;
      ST_P_SR:     stb.pushSel = PS_SR;
      ST_SWITCH:   stb.clrMaster = 1'b1;
      ST_VEC:      stb.readSel = RS_VEC;
      ST_R_SR:     stb.readSel = RS_SR;
      ST_R_PC:     stb.readSel = RS_PC;
      ST_R_FMT:    stb.readSel = RS_FMT;
      ST_R_DEC: begin
        stb.commitThrow = (fmtRd == 4'd1);
        stb.commitRet   = (fmtRd != 4'd1);
      end
      default: ;
    endcase
  end

  assign memReq = (stb.pushSel != PS_NONE) || (stb.readSel != RS_NONE);
  assign busy   = (state != ST_IDLE);
  assign done   = doneQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE; fmtQ <= '0; twoQ <= 1'b0; doneQ <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      unique case (state)
        ST_IDLE:
          if (startEntry) begin
            fmtQ <= firstFmt;
            twoQ <= isHw && oldSrM;
            if (firstFmt == 4'd4) state <= ST_P_CURPC;
            else if (firstFmt == 4'd2 || firstFmt == 4'd3) state <= ST_P_FAULT;
            else state <= ST_P_FMTVEC;
          end else if (startReturn) state <= ST_R_SR;
        ST_P_CURPC:  if (memAck) state <= ST_P_FAULT;
        ST_P_FAULT:  if (memAck) state <= ST_P_FMTVEC;
        ST_P_FMTVEC: if (memAck) state <= ST_P_RETPC;
        ST_P_RETPC:  if (memAck) state <= ST_P_SR;
        ST_P_SR:     if (memAck) state <= twoQ ? ST_SWITCH : ST_VEC;
        ST_SWITCH: begin twoQ <= 1'b0; fmtQ <= 4'd1; state <= ST_P_FMTVEC; end
        ST_VEC:      if (memAck) begin state <= ST_IDLE; doneQ <= 1'b1; end
        ST_R_SR:     if (memAck) state <= ST_R_PC;
        ST_R_PC:     if (memAck) state <= ST_R_FMT;
        ST_R_FMT:    if (memAck) state <= ST_R_DEC;
        ST_R_DEC:
          if (fmtRd == 4'd1) state <= ST_R_SR;
          else begin state <= ST_IDLE; doneQ <= 1'b1; end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R6
  AST_REQ_IN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy); // R12
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> memReq); // R12
endmodule

// File: rtl/exc_frame_seq.sv
module exc_frame_seq
  import exfs_pkg::*;
#(
  parameter int VEC_W = 8,
  parameter logic [15:0] SR_RST = 16'h2700,
  parameter bit SP_ALIGN = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startEntry,
  input  logic             startReturn,
  input  logic             isHw,
  input  logic [3:0]       entryFmt,
  input  logic [VEC_W-1:0] vecNum,
  input  logic [15:0]      oldSr,
  input  logic [2:0]       pendLevel,
  input  logic [31:0]      retPc,
  input  logic [31:0]      curPc,
  input  logic [31:0]      faultAddr,
  input  logic [31:0]      vbr,
  input  logic             spWrEn,
  input  logic [1:0]       spWrSel,
  input  logic [31:0]      spWrData,
  output logic             memReq,
  output logic             memWe,
  output logic             memLong,
  output logic [31:0]      memAddr,
  output logic [31:0]      memWData,
  input  logic [31:0]      memRData,
  input  logic             memAck,
  output logic             busy,
  output logic             done,
  output logic [15:0]      srOut,
  output logic [31:0]      pcOut,
  output logic [31:0]      spOut
);
  strobe_t stb;
  logic ackQual;
  logic [3:0] fmtRd;

  assign ackQual = memAck && memReq;

  exfs_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startEntry(startEntry), .startReturn(startReturn),
    .isHw(isHw), .oldSrM(oldSr[SR_M]), .entryFmt(entryFmt), .memAck(ackQual),
    .fmtRd(fmtRd), .stb(stb), .memReq(memReq), .busy(busy), .done(done)
  );

  exfs_datapath #(.VEC_W(VEC_W), .SR_RST(SR_RST), .SP_ALIGN(SP_ALIGN)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .memAck(ackQual), .isHw(isHw),
    .oldSr(oldSr), .pendLevel(pendLevel), .vecNum(vecNum), .retPc(retPc),
    .curPc(curPc), .faultAddr(faultAddr), .vbr(vbr), .spWrEn(spWrEn),
    .spWrSel(spWrSel), .spWrData(spWrData), .memRData(memRData),
    .memAddr(memAddr), .memWData(memWData), .memWe(memWe), .memLong(memLong),
    .fmtRd(fmtRd), .srOut(srOut), .pcOut(pcOut), .spOut(spOut)
  );
endmodule

// File: tb/tb_exc_frame_seq.sv
module tb_exc_frame_seq;
  logic clk = 0, rstN = 0;
  logic startEntry = 0, startReturn = 0, isHw = 0, spWrEn = 0;
  logic [3:0] entryFmt = 0;
  logic [7:0] vecNum = 0;
  logic [15:0] oldSr = 0;
  logic [2:0] pendLevel = 0;
  logic [31:0] retPc = 0, curPc = 0, faultAddr = 0, vbr = 32'h400, spWrData = 0;
  logic [1:0] spWrSel = 0;
  logic memReq, memWe, memLong, memAck = 0, busy, done;
  logic [31:0] memAddr, memWData, memRData, pcOut, spOut;
  logic [15:0] srOut;
  logic [7:0] mem [0:4095];
  logic [11:0] ma;
  int nChk = 0, nFail = 0;

  always #10 clk = ~clk;

  exc_frame_seq dut (.*);

  assign ma = memAddr[11:0];
  assign memRData = memLong ? {mem[ma], mem[ma+12'd1], mem[ma+12'd2], mem[ma+12'd3]}
                            : {16'h0, mem[ma], mem[ma+12'd1]};

  always @(posedge clk) begin
    if (!rstN) memAck <= 1'b0;
    else memAck <= memReq && !memAck;
    if (memReq && memAck && memWe) begin
      if (memLong) begin
        mem[ma] <= memWData[31:24]; mem[ma+12'd1] <= memWData[23:16];
        mem[ma+12'd2] <= memWData[15:8]; mem[ma+12'd3] <= memWData[7:0];
      end else begin
        mem[ma] <= memWData[15:8]; mem[ma+12'd1] <= memWData[7:0];
      end
    end
  end

  function automatic logic [15:0] rdW(input int a);
    return {mem[a], mem[a+1]};
  endfunction
  function automatic logic [31:0] rdL(input int a);
    return {mem[a], mem[a+1], mem[a+2], mem[a+3]};
  endfunction
  task automatic wrW(input int a, input logic [15:0] d);
    mem[a] = d[15:8]; mem[a+1] = d[7:0];
  endtask
  task automatic wrL(input int a, input logic [31:0] d);
    mem[a] = d[31:24]; mem[a+1] = d[23:16]; mem[a+2] = d[15:8]; mem[a+3] = d[7:0];
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  endtask

  task automatic doReset();
    rstN = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
    @(negedge clk);
  endtask

  task automatic loadSp(input logic [1:0] sel, input logic [31:0] val);
    spWrEn = 1; spWrSel = sel; spWrData = val;
    @(negedge clk);
    spWrEn = 0;
  endtask

  task automatic waitDone(input string req);
    int n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    if (!done) begin nChk++; nFail++; $display("FAIL %s: timeout waiting for done", req); end
  endtask

  task automatic doEntry(input logic hw, input logic [3:0] fmt, input logic [7:0] vec,
                         input logic [15:0] sr, input logic [2:0] pend);
    wrL(32'h400 + vec * 4, 32'h1000_0000 | vec);
    isHw = hw; entryFmt = fmt; vecNum = vec; oldSr = sr; pendLevel = pend;
    retPc = 32'h00AB_0000 | vec; curPc = 32'h00CD_0000 | vec; faultAddr = 32'h00EF_0000 | vec;
    startEntry = 1;
    @(negedge clk);
    startEntry = 0;
    chk("R6 busy", busy, 1);
    waitDone("R6 entry");
  endtask

  task automatic doReturn();
    startReturn = 1;
    @(negedge clk);
    startReturn = 0;
    waitDone("R9 return");
  endtask

  // packed row: {hw[3:0], fmt[3:0], pend[3:0], vec[7:0], oldSr[15:0]}
  localparam logic [35:0] ROWS [7] = '{
    {4'd0, 4'd0, 4'd0, 8'd4,  16'h0000},
    {4'd0, 4'd2, 4'd0, 8'd5,  16'h8015},
    {4'd0, 4'd3, 4'd0, 8'd6,  16'h2700},
    {4'd0, 4'd4, 4'd0, 8'd7,  16'h0010},
    {4'd1, 4'd4, 4'd2, 8'd26, 16'h0000},
    {4'd0, 4'd0, 4'd0, 8'd32, 16'h3004},
    {4'd1, 4'd0, 4'd6, 8'd31, 16'hA700}
  };

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog: run did not finish");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    doReset();
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 sr", srOut, 16'h2700);
    chk("R1 pc", pcOut, 0);
    chk("R1 sp", spOut, 0);
    // R13 stack load, R11 interrupt stack active under 0x2700
    loadSp(2'd1, 32'h800);
    chk("R13 isp load", spOut, 32'h800);

    for (int r = 0; r < 7; r++) begin
      logic hw; logic [3:0] fmt, eff; logic [2:0] pend; logic [7:0] vec;
      logic [15:0] sr, eSr; int extra, base, sp, retSp;
      {hw, fmt, pend, vec, sr} = {ROWS[r][32], ROWS[r][31:28], ROWS[r][26:24], ROWS[r][23:16], ROWS[r][15:0]};
      loadSp(2'd0, 32'h600); loadSp(2'd1, 32'h800); loadSp(2'd2, 32'hC00);
      doEntry(hw, fmt, vec, sr, pend);
      eSr = (sr | 16'h2000) & 16'h7FFF;
      if (hw) eSr[10:8] = pend;
      eff = hw ? 4'd0 : fmt;
      extra = (eff == 2 || eff == 3) ? 4 : (eff == 4) ? 8 : 0;
      base = sr[12] ? 32'hC00 : 32'h800;
      sp = base - 8 - extra;
      chk("R6 handler pc", pcOut, 32'h1000_0000 | vec);
      chk("R2 entry sr", srOut, eSr);
      chk("R11 R3 sp after entry", spOut, sp);
      chk("R3 frame sr", rdW(sp), sr);
      chk("R3 frame pc", rdL(sp + 2), 32'h00AB_0000 | vec);
      chk("R5 fmt/vec word", rdW(sp + 6), {eff, 12'(vec * 4)});
      if (extra >= 4) chk("R4 fault addr", rdL(sp + 8), 32'h00EF_0000 | vec);
      if (extra == 8) chk("R4 current pc", rdL(sp + 12), 32'h00CD_0000 | vec);
      @(negedge clk);
      chk("R6 done one cycle", done, 0);
      doReturn();
      retSp = !sr[13] ? 32'h600 : (sr[12] ? 32'hC00 : 32'h800);
      chk("R9 return pc", pcOut, 32'h00AB_0000 | vec);
      chk("R9 return sr", srOut, sr);
      chk("R9 R11 return sp", spOut, retSp);
    end

    // R7 odd stack pointer is aligned before pushing
    doReset();
    loadSp(2'd1, 32'h801);
    doEntry(0, 4'd0, 8'd9, 16'h2000, 3'd0);
    chk("R7 aligned sp", spOut, 32'h7F8);
    chk("R7 frame sr", rdW(32'h7F8), 16'h2000);

    // R8 hardware interrupt in master mode: two frames
    doReset();
    loadSp(2'd1, 32'h800); loadSp(2'd2, 32'hC00);
    doEntry(1, 4'd0, 8'd29, 16'h3000, 3'd5);
    chk("R8 sr", srOut, 16'h2500);
    chk("R8 isp", spOut, 32'h7F8);
    chk("R8 pc", pcOut, 32'h1000_001D);
    chk("R8 master sr", rdW(32'hBF8), 16'h3000);
    chk("R8 master pc", rdL(32'hBFA), 32'h00AB_001D);
    chk("R8 master fmt", rdW(32'hBFE), 16'h0074);
    chk("R8 int sr", rdW(32'h7F8), 16'h3500);
    chk("R8 int pc", rdL(32'h7FA), 32'h00AB_001D);
    chk("R8 int fmt", rdW(32'h7FE), 16'h1074);
    // R10 unwinding both frames
    doReturn();
    chk("R10 sr", srOut, 16'h3000);
    chk("R10 pc", pcOut, 32'h00AB_001D);
    chk("R10 msp", spOut, 32'hC00);

    // R9 format 7 skip of 52 bytes
    doReset();
    loadSp(2'd1, 32'h900);
    wrW(32'h900, 16'h2700); wrL(32'h902, 32'h1234_5678); wrW(32'h906, 16'h7008);
    doReturn();
    chk("R9 fmt7 sp", spOut, 32'h93C);
    chk("R9 fmt7 pc", pcOut, 32'h1234_5678);
    chk("R9 fmt7 sr", srOut, 16'h2700);

    // R10 throwaway frame switches to master stack
    doReset();
    loadSp(2'd0, 32'h600); loadSp(2'd1, 32'h700); loadSp(2'd2, 32'hB00);
    wrW(32'h700, 16'h3000); wrL(32'h702, 32'h1111_1111); wrW(32'h706, 16'h1064);
    wrW(32'hB00, 16'h0004); wrL(32'hB02, 32'hCAFE_0000); wrW(32'hB06, 16'h0000);
    doReturn();
    chk("R10 throw sr", srOut, 16'h0004);
    chk("R10 throw pc", pcOut, 32'hCAFE_0000);
    chk("R10 R11 user sp", spOut, 32'h600);
    doEntry(0, 4'd0, 8'd4, 16'h0004, 3'd0);
    chk("R10 isp popped", spOut, 32'h700);

    finishRun();
  end
endmodule